// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block is a small configuration space reached through a pair of byte-wide I/O ports. The host first writes a register number into the index port. It then reads or writes the data port, which lands on whichever register that number names. Two global registers identify the part: a fixed identification byte and a revision byte. A third global register chooses one of several logical devices. Every index from 0x30 upward then refers to the register bank of that device.

Each logical device has an enable flag and a 16-bit base address. The block presents all of these to the rest of the chip as flat registered outputs, so each function can decode its own address range and switch itself on. The pair of ports sits at one of two base addresses, picked by a strap pin that is captured during reset.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the latched index is 0x00, the selected device number is 0x00, every device is inactive with base address 0x0000, and `io_rdata` is 0xFF.
- R2: The strap level during reset selects the port pair: index port at 0x002E and data port at 0x002F when low, 0x004E and 0x004F when high. A change of the strap after reset has no effect. Accesses to any other address are ignored, and a read of one returns 0xFF.
- R3: A write to the index port latches the index. A read of the index port returns it. The index keeps its value across any number of data-port accesses.
- R4: Index 0x20 reads 0xE9, and writes to it are ignored.
- R5: Index 0x27 reads the revision parameter (default 0x03), and writes to it are ignored.
- R6: A write to index 0x07 sets the selected device number (all 8 bits). A read of index 0x07 returns it.
- R7: At index 0x30, bit 0 of a write sets the selected device's enable and the other bits are discarded. A read returns the enable in bit 0 with zeros above it. `dev_active[d]` shows the new value one cycle after the write.
- R8: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base address, exported on `dev_base[16*d +: 16]`.
- R9: A read of an index with no register behind it, or of a bank index while the selected device number is NUM_DEV or higher, returns 0xFF. Writes to such targets change nothing.
- R10: `io_rdata` is loaded on the clock edge that samples `io_rd` and holds its value until the next read. When read and write strobes hit the same register in the same cycle, the read returns the value from before the write, and the write takes effect.
- R11: A bank write changes only the registers of the selected device. The other devices keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the strap |
| strap_alt | input | 1 | Base address select strap (0: 0x2E, 1: 0x4E) |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data byte |
| dev_active | output | NUM_DEV | Enable flag per logical device |
| dev_base | output | 16*NUM_DEV | Base address per logical device, device d at bits 16*d+15:16*d |

## Verification
A data-port read and a data-port write can fall in the same cycle on the same register. In that case the read mux and the register update compete for one clock edge. The bench raises both strobes together on the low base-address byte of a device. It expects the read to return the byte from before the write, and then expects a later read and the exported `dev_base` to show the new byte. The bench also makes sure a bank write never disturbs a neighbouring device, and it switches the strap after reset to show that the port location stays fixed until the next reset.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int BASE_W = 16;

  localparam logic [7:0] IDX_LDN  = 8'h07;
  localparam logic [7:0] IDX_ID   = 8'h20;
  localparam logic [7:0] IDX_REV  = 8'h27;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] IDX_BHI  = 8'h60;
  localparam logic [7:0] IDX_BLO  = 8'h61;
  localparam logic [7:0] NO_REG   = 8'hFF;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_ACT  = 2'd1,
    BR_BHI  = 2'd2,
    BR_BLO  = 2'd3
  } bank_reg_e;

  function automatic bank_reg_e bank_of(input logic [7:0] idx);
    case (idx)
      IDX_ACT: return BR_ACT;
      IDX_BHI: return BR_BHI;
      IDX_BLO: return BR_BLO;
      default: return BR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        idx,
  output logic              idx_rd,
  output logic              dat_rd,
  output logic              dat_wr
);
  logic              alt_q;
  logic [ADDR_W-1:0] base;
  logic              at_idx, at_dat;

  assign base   = alt_q ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);
  assign at_idx = (io_addr == base);
  assign at_dat = (io_addr == base + ADDR_W'(1));

  assign idx_rd = io_rd && at_idx;
  assign dat_rd = io_rd && at_dat;
  assign dat_wr = io_wr && at_dat;

  always_ff @(posedge clk) begin
    if (rst) alt_q <= strap_alt;
  end

  always_ff @(posedge clk) begin
    if (rst)                  idx <= 8'h00;
    else if (io_wr && at_idx) idx <= io_wdata;
  end

  assert_strap_held_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(alt_q));

  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && at_idx) |=> $stable(idx));
endmodule

// File: rtl/cfgport_devbank.sv
module cfgport_devbank
  import cfgport_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [7:0]                ldn,
  input  logic                      wr_en,
  input  bank_reg_e                 reg_sel,
  input  logic [7:0]                wdata,
  output logic                      sel_valid,
  output logic [7:0]                sel_byte,
  output logic [NUM_DEV-1:0]        dev_active,
  output logic [NUM_DEV*BASE_W-1:0] dev_base
);
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic              act_q  [NUM_DEV];
  logic [BASE_W-1:0] base_q [NUM_DEV];
  logic [SEL_W-1:0]  sel;

  assign sel_valid = ({24'd0, ldn} < NUM_DEV);
  assign sel       = ldn[SEL_W-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = wr_en && sel_valid && (ldn == 8'(d));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[d]  <= 1'b0;
        base_q[d] <= '0;
      end else if (hit) begin
        case (reg_sel)
          BR_ACT:  act_q[d]        <= wdata[0];
          BR_BHI:  base_q[d][15:8] <= wdata;
          BR_BLO:  base_q[d][7:0]  <= wdata;
          default: ;
        endcase
      end
    end

    assign dev_active[d]             = act_q[d];
    assign dev_base[d*BASE_W +: BASE_W] = base_q[d];

    assert_other_dev_kept_R11: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && ldn == 8'(d)) |=> ($stable(dev_active[d]) &&
                                    $stable(dev_base[d*BASE_W +: BASE_W])));
  end

  always_comb begin
    sel_byte = NO_REG;
    if (sel_valid) begin
      case (reg_sel)
        BR_ACT:  sel_byte = {7'd0, act_q[sel]};
        BR_BHI:  sel_byte = base_q[sel][15:8];
        BR_BLO:  sel_byte = base_q[sel][7:0];
        default: sel_byte = NO_REG;
      endcase
    end
  end
endmodule

// File: rtl/cfgport_rdmux.sv
module cfgport_rdmux
  import cfgport_pkg::*;
#(
  parameter logic [7:0] CHIP_ID  = 8'hE9,
  parameter logic [7:0] CHIP_REV = 8'h03
) (
  input  logic       idx_rd,
  input  logic       dat_rd,
  input  logic [7:0] idx,
  input  logic [7:0] ldn,
  input  logic [7:0] bank_byte,
  output logic [7:0] rd_byte
);
  always_comb begin
    rd_byte = NO_REG;
    if (idx_rd) begin
      rd_byte = idx;
    end else if (dat_rd) begin
      case (idx)
        IDX_LDN: rd_byte = ldn;
        IDX_ID:  rd_byte = CHIP_ID;
        IDX_REV: rd_byte = CHIP_REV;
        default: rd_byte = (bank_of(idx) != BR_NONE) ? bank_byte : NO_REG;
      endcase
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgport_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E,
  parameter logic [7:0]  CHIP_ID  = 8'hE9,
  parameter logic [7:0]  CHIP_REV = 8'h03
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      strap_alt,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic                      io_wr,
  input  logic                      io_rd,
  input  logic [7:0]                io_wdata,
  output logic [7:0]                io_rdata,
  output logic [NUM_DEV-1:0]        dev_active,
  output logic [NUM_DEV*BASE_W-1:0] dev_base
);
  logic [7:0] idx, ldn_q, bank_byte, rd_byte;
  logic       idx_rd, dat_rd, dat_wr, sel_valid;
  bank_reg_e  reg_sel;

  cfgport_decode #(
    .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT)
  ) u_decode (
    .clk(clk), .rst(rst), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .idx(idx),
    .idx_rd(idx_rd), .dat_rd(dat_rd), .dat_wr(dat_wr)
  );

  assign reg_sel = bank_of(idx);

  always_ff @(posedge clk) begin
    if (rst)                           ldn_q <= 8'h00;
    else if (dat_wr && idx == IDX_LDN) ldn_q <= io_wdata;
  end

  cfgport_devbank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk(clk), .rst(rst), .ldn(ldn_q), .wr_en(dat_wr), .reg_sel(reg_sel),
    .wdata(io_wdata), .sel_valid(sel_valid), .sel_byte(bank_byte),
    .dev_active(dev_active), .dev_base(dev_base)
  );

  cfgport_rdmux #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_rdmux (
    .idx_rd(idx_rd), .dat_rd(dat_rd), .idx(idx), .ldn(ldn_q),
    .bank_byte(bank_byte), .rd_byte(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= NO_REG;
    else if (io_rd) io_rdata <= rd_byte;
  end

  assert_id_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && idx == IDX_ID) |=> (io_rdata == CHIP_ID));

  assert_unpop_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !sel_valid) |=> ($stable(dev_active) && $stable(dev_base)));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/cfg_index_port_test.sv
`timescale 1ns/1ps
module cfg_index_port_test;
  localparam int ND = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             strap_alt = 1'b0;
  logic [15:0]      io_addr = '0;
  logic             io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]       io_wdata = '0;
  logic [7:0]       io_rdata;
  logic [ND-1:0]    dev_active;
  logic [ND*16-1:0] dev_base;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [15:0] P = 16'h002E;

  always #4 clk = ~clk;

  cfg_index_port #(.NUM_DEV(ND)) uut (
    .clk(clk), .rst(rst), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dev_active(dev_active), .dev_base(dev_base)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst = 1'b1; strap_alt = strap;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(P, i); wr(P + 16'd1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(P, i); rd(P + 16'd1, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rdata", io_rdata, 8'hFF);
    chk("R1 active", dev_active, '0);
    chk("R1 base", dev_base, '0);
    rd(P, v);        chk("R1 index", v, 8'h00);
    rd(P + 1, v);    chk("R1 data at idx0 R9", v, 8'hFF);
    reg_rd(8'h07, v); chk("R1 ldn", v, 8'h00);
  endtask

  task automatic t_index_id_rev;
    logic [7:0] v;
    wr(P, 8'h20);
    rd(P, v);     chk("R3 index readback", v, 8'h20);
    rd(P + 1, v); chk("R4 id", v, 8'hE9);
    rd(P + 1, v); chk("R3 id repeat", v, 8'hE9);
    wr(P + 1, 8'h55);
    rd(P + 1, v); chk("R4 id write ignored", v, 8'hE9);
    rd(P, v);     chk("R3 index held", v, 8'h20);
    reg_wr(8'h27, 8'h77);
    rd(P + 1, v); chk("R5 rev", v, 8'h03);
  endtask

  task automatic t_banks;
    logic [7:0] v;
    reg_wr(8'h07, 8'h02);
    rd(P + 1, v); chk("R6 ldn readback", v, 8'h02);
    reg_wr(8'h30, 8'hFF);
    chk("R7 active export", dev_active, 4'b0100);
    rd(P + 1, v); chk("R7 act read", v, 8'h01);
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    chk("R8 base dev2", dev_base[2*16 +: 16], 16'h1234);
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h30, 8'h01); reg_wr(8'h60, 8'hAB); reg_wr(8'h61, 8'hCD);
    chk("R11 dev2 kept", dev_base[2*16 +: 16], 16'h1234);
    chk("R11 active", dev_active, 4'b0110);
    chk("R8 base dev1", dev_base[1*16 +: 16], 16'hABCD);
    chk("R11 dev0 untouched", dev_base[0 +: 16], 16'h0000);
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h60, v); chk("R8 hi readback", v, 8'h12);
    reg_rd(8'h61, v); chk("R8 lo readback", v, 8'h34);
    reg_wr(8'h30, 8'h02);
    chk("R7 bit0 only", dev_active, 4'b0010);
  endtask

  task automatic t_unpop;
    logic [7:0] v;
    logic [ND*16-1:0] b0;
    logic [ND-1:0] a0;
    b0 = dev_base; a0 = dev_active;
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h30, v); chk("R9 unpop act read", v, 8'hFF);
    reg_wr(8'h30, 8'h01); reg_wr(8'h60, 8'h99); reg_wr(8'h61, 8'h99);
    chk("R9 unpop active", dev_active, a0);
    chk("R9 unpop base", dev_base, b0);
    reg_wr(8'h45, 8'h5A);
    rd(P + 1, v); chk("R9 unimpl index", v, 8'hFF);
    chk("R9 unimpl no side effect", dev_base, b0);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    reg_wr(8'h07, 8'h01);
    wr(P, 8'h61);
    @(negedge clk); io_addr = P + 1; io_wdata = 8'h77; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
    chk("R10 read before write", io_rdata, 8'hCD);
    chk("R10 write applied", dev_base[1*16 +: 16], 16'hAB77);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", io_rdata, 8'hCD);
    rd(P + 1, v); chk("R10 new value", v, 8'h77);
  endtask

  task automatic t_strap;
    logic [7:0] v;
    strap_alt = 1'b1;
    wr(16'h004E, 8'h20);
    rd(16'h004F, v); chk("R2 strap change ignored", v, 8'hFF);
    rd(P, v);        chk("R2 index unchanged", v, 8'h61);
    rd(16'h0100, v); chk("R2 miss read", v, 8'hFF);
    do_reset(1'b1);
    P = 16'h004E;
    rd(P, v);     chk("R2 alt index", v, 8'h00);
    wr(P, 8'h20);
    rd(P + 1, v); chk("R2 alt data", v, 8'hE9);
    rd(16'h002F, v); chk("R2 old port dead", v, 8'hFF);
    chk("R1 active after reset", dev_active, '0);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset;
    t_index_id_rev;
    t_banks;
    t_unpop;
    t_same_cycle;
    t_strap;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule